// File: doc/BRIEF.md
# Capture Trigger with Pre-Trigger History

This block sits behind a sampled digital bus and records one sample per clock into a circular capture memory. While it records, it watches the samples for a trace point. That point is either a pattern (each bus bit compared against a wanted level, with a per-bit mask that turns the bit into a don't-care) or a rising or falling transition on one chosen bus line. Recording never waits for the trace point. The memory therefore already holds history from before the event when the event arrives.

When the trace point is found, the block latches the memory address of that sample. It then records a programmable number of further samples, stops writing, and raises a done flag. A minimum amount of pre-trigger history is enforced: the trace point is only accepted once enough samples have been written since arming. The memory then holds a valid pre-event region and a post-event region. Software or a readout engine uses the latched address to unroll the circular memory. An arm pulse starts or restarts a capture at any time.

Top module: `capture_trigger`

## Requirements
- R1: Out of reset, `mem_we` and `done` are low and `trig_addr` is 0.
- R2: A capture starts on the clock after `arm` is high. From then on, one sample is written per clock while capturing. Writing starts at address 0 and steps by one, wrapping from DEPTH-1 to 0, and `mem_data` equals the current `smp`.
- R3: With `cfg_mode` = 0 (pattern), a sample is a hit when it equals `cfg_pat` on every bit position whose `cfg_care` bit is 1. Bits whose `cfg_care` bit is 0 are ignored.
- R4: With `cfg_mode` = 1 (edge), a sample is a hit when bus line `cfg_line` differs from its value in the previous captured sample and now equals `cfg_rising` (1 = rising, 0 = falling). The first sample after arming is never an edge hit.
- R5: A hit on sample index i, counted from 0 after arming, is ignored unless i >= `cfg_pre`.
- R6: After the accepted trace point, exactly `cfg_post` more samples are written (none when `cfg_post` = 0). On the next clock `mem_we` is low and `done` is high, and both hold until the next arm.
- R7: From the clock after the trace point, `trig_addr` holds the address at which the trace-point sample was written. It keeps that value until the next arm.
- R8: Only the first accepted hit after arming is the trace point. Later hits change neither `trig_addr` nor the stop time.
- R9: Without an accepted hit, capture continues indefinitely with the address wrapping, and `done` stays low.
- R10: An `arm` pulse during a running capture restarts it: the address returns to 0 and the pre-trigger count and edge history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart a capture |
| smp | input | W | Sampled bus |
| cfg_mode | input | 1 | 0 = pattern trigger, 1 = edge trigger |
| cfg_pat | input | W | Wanted bit levels in pattern mode |
| cfg_care | input | W | 1 = bit takes part in the pattern compare |
| cfg_line | input | $clog2(W) | Bus line watched in edge mode |
| cfg_rising | input | 1 | 1 = rising edge, 0 = falling edge |
| cfg_pre | input | $clog2(DEPTH)+1 | Minimum samples before a trace point is accepted |
| cfg_post | input | PW | Samples written after the trace point |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | $clog2(DEPTH) | Capture memory write address |
| mem_data | output | W | Capture memory write data |
| done | output | 1 | Capture finished |
| trig_addr | output | $clog2(DEPTH) | Address of the trace-point sample |

## Verification
The bench sweeps both trigger modes against pre-trigger limits of 0, a middle value and the full depth, and post-trigger counts of 0, a small value and nearly the full depth. Each combination runs over several generated sample streams, and every write is compared with a model that computes the trace-point index arithmetically. Each corner case targets a specific fault:
- A post counter that is off by one would write one sample too many or too few, and `done` would rise a clock early or late.
- A pre-trigger check that compares against the wrong count would accept an early hit.
- Edge logic that treats the reset value as history would fire on the first sample.
- A design that re-latches on later hits would move `trig_addr`.

One run feeds a constant bus so that nothing ever triggers and the address must wrap for many laps. The next run is armed while that capture is still going, to catch a restart that keeps the old address or edge history.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic {
        TRIG_PATTERN = 1'b0,
        TRIG_EDGE    = 1'b1
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic capturing;
        logic finished;
    } cap_flags_t;

endpackage

// File: rtl/trig_match.sv
module trig_match
    import trig_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    input  logic [W-1:0]  smp,
    input  trig_mode_e    mode,
    input  logic [W-1:0]  pat,
    input  logic [W-1:0]  care,
    input  logic [LW-1:0] line,
    input  logic          rising,
    output logic          hit
);
    logic [W-1:0] prev_smp;
    logic         prev_ok;
    logic [W-1:0] bit_ok;
    logic         pat_hit;
    logic         edge_hit;
    logic         now_bit;
    logic         old_bit;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign bit_ok[b] = ~care[b] | (smp[b] ~^ pat[b]);
    end

    assign pat_hit  = &bit_ok;
    assign now_bit  = smp[line];
    assign old_bit  = prev_smp[line];
    assign edge_hit = prev_ok && (now_bit != old_bit) && (now_bit == rising);
    assign hit      = (mode == TRIG_EDGE) ? edge_hit : pat_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_smp <= '0;
            prev_ok  <= 1'b0;
        end else if (restart) begin
            prev_ok  <= 1'b0;
        end else if (advance) begin
            prev_smp <= smp;
            prev_ok  <= 1'b1;
        end
    end

    // R4: an edge hit needs a sample captured since the last arm
    a_r4_edge_history: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && !prev_ok) |-> !hit);

endmodule

// File: rtl/wr_pointer.sv
module wr_pointer #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   fill
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL = (AW + 1)'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            waddr <= '0;
            fill  <= '0;
        end else if (advance) begin
            waddr <= (waddr == LAST) ? '0 : waddr + AW'(1);
            if (fill != FULL) fill <= fill + (AW + 1)'(1);
        end
    end

    // R2: address wraps from the top entry back to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart && waddr == LAST) |=> (waddr == '0));

    // R10: a restart returns the pointer to zero
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> (waddr == '0 && fill == '0));

    // R5: history count never exceeds the memory depth
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
    import trig_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          hit,
    input  logic [AW:0]   fill,
    input  logic [AW:0]   cfg_pre,
    input  logic [PW-1:0] cfg_post,
    input  logic [AW-1:0] waddr,
    output cap_flags_t    flags,
    output logic [AW-1:0] trig_addr
);
    cap_state_e    state;
    logic [PW-1:0] remain;
    logic          fire;

    assign fire            = (state == ST_HUNT) && hit && (fill >= cfg_pre);
    assign flags.capturing = (state == ST_HUNT) || (state == ST_POST);
    assign flags.finished  = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remain    <= '0;
            trig_addr <= '0;
        end else if (arm) begin
            state  <= ST_HUNT;
            remain <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (fire) begin
                        trig_addr <= waddr;
                        remain    <= cfg_post;
                        state     <= (cfg_post == '0) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: begin
                    remain <= remain - PW'(1);
                    if (remain == PW'(1)) state <= ST_DONE;
                end
                default: state <= state;
            endcase
        end
    end

    // R5: leaving the hunt is only allowed with enough history
    a_r5_pre_respected: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && !arm) |=>
            (state == ST_HUNT || $past(fill) >= $past(cfg_pre)));

    // R6: the post phase always has samples left to write
    a_r6_post_live: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POST) |-> (remain != '0));

    // R8: once triggered, no second trace point is latched
    a_r8_single_trigger: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POST && !arm) |=> (state != ST_HUNT && $stable(trig_addr)));

    // R7: finished capture keeps its trace address
    a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !arm) |=> (state == ST_DONE && $stable(trig_addr)));

endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
    import trig_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [W-1:0]  smp,
    input  logic          cfg_mode,
    input  logic [W-1:0]  cfg_pat,
    input  logic [W-1:0]  cfg_care,
    input  logic [LW-1:0] cfg_line,
    input  logic          cfg_rising,
    input  logic [AW:0]   cfg_pre,
    input  logic [PW-1:0] cfg_post,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_data,
    output logic          done,
    output logic [AW-1:0] trig_addr
);
    logic          hit;
    logic [AW-1:0] waddr;
    logic [AW:0]   fill;
    cap_flags_t    flags;
    trig_mode_e    mode;

    assign mode = trig_mode_e'(cfg_mode);

    trig_match #(.W(W), .LW(LW)) u_match (
        .clk     (clk),
        .rst     (rst),
        .restart (arm),
        .advance (flags.capturing),
        .smp     (smp),
        .mode    (mode),
        .pat     (cfg_pat),
        .care    (cfg_care),
        .line    (cfg_line),
        .rising  (cfg_rising),
        .hit     (hit)
    );

    wr_pointer #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .restart (arm),
        .advance (flags.capturing),
        .waddr   (waddr),
        .fill    (fill)
    );

    capture_fsm #(.AW(AW), .PW(PW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .hit       (hit),
        .fill      (fill),
        .cfg_pre   (cfg_pre),
        .cfg_post  (cfg_post),
        .waddr     (waddr),
        .flags     (flags),
        .trig_addr (trig_addr)
    );

    assign mem_we   = flags.capturing;
    assign mem_addr = waddr;
    assign mem_data = smp;
    assign done     = flags.finished;

    // R6: a finished capture leaves memory alone until re-armed
    a_r6_quiet_done: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> !mem_we);

    // R1: leaving reset with nothing written
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!mem_we && !done));

endmodule

// File: tb/tb_capture_trigger.sv
module tb_capture_trigger;
    localparam int W = 4;
    localparam int DEPTH = 8;
    localparam int PW = 4;
    localparam int HORIZON = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       arm;
    logic [3:0] smp;
    logic       cfg_mode;
    logic [3:0] cfg_pat;
    logic [3:0] cfg_care;
    logic [1:0] cfg_line;
    logic       cfg_rising;
    logic [3:0] cfg_pre;
    logic [3:0] cfg_post;
    logic       mem_we;
    logic [2:0] mem_addr;
    logic [3:0] mem_data;
    logic       done;
    logic [2:0] trig_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    capture_trigger #(.W(W), .DEPTH(DEPTH), .PW(PW)) dut (
        .clk(clk), .rst(rst), .arm(arm), .smp(smp), .cfg_mode(cfg_mode),
        .cfg_pat(cfg_pat), .cfg_care(cfg_care), .cfg_line(cfg_line),
        .cfg_rising(cfg_rising), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .done(done), .trig_addr(trig_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<=100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] sgen(int i, int seed);
        if (seed < 0) return 4'h5;
        return 4'((i * (2 * seed + 1) + seed * 3) ^ (i >> 1) ^ (i * i * seed));
    endfunction

    function automatic bit model_hit(int i, int seed, int mode, int pat, int care,
                                     int line, int rise);
        logic [3:0] s;
        logic [3:0] p;
        s = sgen(i, seed);
        if (mode == 0) return ((s ^ 4'(pat)) & 4'(care)) == 4'h0;
        if (i == 0) return 1'b0;
        p = sgen(i - 1, seed);
        return (s[line] != p[line]) && (s[line] == 1'(rise));
    endfunction

    task automatic run_case(input int mode, input int pat, input int care, input int line,
                            input int rise, input int pre, input int post, input int seed,
                            input string tag);
        int t;
        int last;
        int early;
        int later;
        int werr;
        int wfirst;
        int dobs;
        int pwrites;
        t = -1;
        early = 0;
        later = 0;
        for (int i = 0; i < HORIZON; i++) begin
            if (model_hit(i, seed, mode, pat, care, line, rise)) begin
                if (i < pre) early = 1;
                else if (t < 0) t = i;
                else later = 1;
            end
        end
        last = (t < 0) ? 1000000 : t + post;
        werr = 0;
        wfirst = -1;
        dobs = -1;
        pwrites = 0;
        @(negedge clk);
        arm = 1'b1;
        cfg_mode = 1'(mode);
        cfg_pat = 4'(pat);
        cfg_care = 4'(care);
        cfg_line = 2'(line);
        cfg_rising = 1'(rise);
        cfg_pre = 4'(pre);
        cfg_post = 4'(post);
        for (int i = 0; i < HORIZON; i++) begin
            @(negedge clk);
            arm = 1'b0;
            smp = sgen(i, seed);
            #1;
            if (i <= last) begin
                if (!(mem_we && mem_addr == 3'(i % DEPTH) && mem_data == smp)) begin
                    werr++;
                    if (wfirst < 0) wfirst = i;
                end
            end else if (mem_we) begin
                werr++;
                if (wfirst < 0) wfirst = i;
            end
            if (t >= 0 && i > t && mem_we) pwrites++;
            if (done && dobs < 0) dobs = i;
        end
        check(werr == 0, {tag, "/R2 write stream"}, wfirst, -1);
        check(dobs == ((t < 0) ? -1 : last + 1), {tag, " done timing"}, dobs,
              (t < 0) ? -1 : last + 1);
        if (t >= 0) begin
            check(pwrites == post, "R6 post-trigger writes", pwrites, post);
            check(trig_addr == 3'(t % DEPTH), "R7 trace address", int'(trig_addr), t % DEPTH);
            if (early) check(dobs == last + 1, "R5 early hit ignored", dobs, last + 1);
            if (later) check(trig_addr == 3'(t % DEPTH), "R8 later hit ignored",
                             int'(trig_addr), t % DEPTH);
        end else begin
            check(!done, "R9 no trigger keeps running", int'(done), 0);
        end
    endtask

    initial begin
        rst = 1'b1;
        arm = 1'b0;
        smp = '0;
        cfg_mode = 1'b0;
        cfg_pat = '0;
        cfg_care = '0;
        cfg_line = '0;
        cfg_rising = 1'b0;
        cfg_pre = '0;
        cfg_post = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!mem_we, "R1 reset write enable", int'(mem_we), 0);
        check(!done, "R1 reset done", int'(done), 0);
        check(trig_addr == 3'd0, "R1 reset trace address", int'(trig_addr), 0);

        for (int m = 0; m < 2; m++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int qi = 0; qi < 3; qi++) begin
                    for (int s = 1; s <= 3; s++) begin
                        automatic int pre = (pi == 0) ? 0 : (pi == 1) ? 3 : 8;
                        automatic int post = (qi == 0) ? 0 : (qi == 1) ? 2 : 7;
                        automatic int care = (s == 1) ? 15 : (s == 2) ? 5 : 12;
                        run_case(m, (s * 7) & 15, care, s % 4, s & 1, pre, post, s,
                                 (m == 0) ? "R3 pattern" : "R4 edge");
                    end
                end
            end
        end
        // don't-care everywhere: trace point lands exactly at the pre limit
        run_case(0, 9, 0, 0, 0, 5, 1, 2, "R3 all masked");
        // constant bus: no edge ever, capture keeps wrapping
        run_case(1, 0, 0, 2, 1, 0, 3, -1, "R9 idle bus");
        // armed while the previous capture is still running
        run_case(1, 0, 0, 1, 0, 2, 3, 3, "R10 re-arm mid capture");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule